// File: doc/BRIEF.md
# Per-Core Interval Counter Arbiter

This block issues shared-memory access strobes to 16 cores without a slot table. Each core has its own 7-bit counter, an interval register and a seed register. A core is strobed when its counter equals its interval minus one. The same match clears that counter to zero, so a core with interval N is strobed once every N cycles. The seed registers set where each counter starts, which lets the cores run out of phase with one another.

Software writes the interval and seed registers through a small write port. A load pulse copies every seed into its counter at once and starts the block running. After reset every interval is 16 and core i is seeded with i, so a single load gives plain round-robin access.

When two or more cores match in the same cycle, the block raises a collision flag. It passes on only the strobe of the lowest-numbered matching core. Every matching counter is still cleared, so each core keeps its own cadence.

Top module: `core_interval_arb`

## Requirements
- R1: After reset the block is idle: every interval reads as 16, the seed of core i is i, and both `strobe_o` and `collide_o` stay 0 until the first `load` pulse, however long that takes.
- R2: A `load` pulse copies all 16 seed registers into the counters on the same clock edge and starts the block. A seed written in that same cycle is not used by that load.
- R3: With interval N (1..127), core i strobes in each cycle where its counter equals N-1. The counter then returns to 0, so strobes repeat exactly every N cycles. While running, a counter that does not match increments by 1.
- R4: With the reset intervals and seeds, a load gives round-robin access. Exactly one core strobes in every cycle, in the order 15, 14, ..., 0, starting in the first cycle after the load edge.
- R5: An interval of 0 disables a core. It never strobes, and its counter wraps from 127 to 0.
- R6: A counter that is above its target keeps counting, wraps from 127 to 0, and then matches normally.
- R7: When two or more cores match in one cycle, `collide_o` is 1. `strobe_o` carries only the lowest-numbered matching core, and every matching counter is cleared.
- R8: `strobe_o` never has more than one bit set.
- R9: A write with `cfg_sel`=0 sets the interval of core `cfg_idx`, and `cfg_sel`=1 sets its seed, both from `cfg_data`. A new interval is used for matching from the next cycle on.
- R10: A `load` while the block is running restarts every counter from its seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 1 | Register select: 0 = interval, 1 = seed |
| cfg_idx | input | 4 | Core number the write targets |
| cfg_data | input | 7 | Value written |
| load | input | 1 | Copy seeds into counters and start |
| strobe_o | output | 16 | Access strobe, one bit per core, at most one set |
| collide_o | output | 1 | Two or more cores matched this cycle |

## Verification
A wrong counter, interval or seed shows up at `strobe_o` the first time that core should have matched, or should not have. That is within one interval of the fault, and after at most 128 cycles when a counter has to wrap. A bad run flag shows up in the first cycle after reset or after a load. The bench keeps its own model of every counter and compares both outputs on every cycle, so a fault is reported in the cycle it first reaches the ports.

// File: rtl/core_interval_arb.sv
module core_interval_arb #(
  parameter int N_CORES = 16,
  parameter int CNT_W   = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic                       cfg_sel,
  input  logic [$clog2(N_CORES)-1:0] cfg_idx,
  input  logic [CNT_W-1:0]           cfg_data,
  input  logic                       load,
  output logic [N_CORES-1:0]         strobe_o,
  output logic                       collide_o
);

  localparam logic [CNT_W-1:0] IVL_RST = CNT_W'(N_CORES);

  logic [CNT_W-1:0]   cnt_q  [N_CORES];
  logic [CNT_W-1:0]   ivl_q  [N_CORES];
  logic [CNT_W-1:0]   seed_q [N_CORES];
  logic               run_q;
  logic [N_CORES-1:0] hit;

  always_ff @(posedge clk) begin
    if (!rst_n)    run_q <= 1'b0;
    else if (load) run_q <= 1'b1;
  end

  for (genvar g = 0; g < N_CORES; g++) begin : g_core
    assign hit[g] = run_q && (ivl_q[g] != '0) && (cnt_q[g] == ivl_q[g] - 1'b1);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q[g]  <= CNT_W'(g);
        ivl_q[g]  <= IVL_RST;
        seed_q[g] <= CNT_W'(g);
      end else begin
        if (load)       cnt_q[g] <= seed_q[g];
        else if (run_q) cnt_q[g] <= hit[g] ? '0 : cnt_q[g] + 1'b1;
        if (cfg_we && cfg_idx == g) begin
          if (cfg_sel) seed_q[g] <= cfg_data;
          else         ivl_q[g]  <= cfg_data;
        end
      end
    end

    // R3: a match clears the counter
    a_r3_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
      hit[g] && !load |=> cnt_q[g] == '0);
    // R2: load copies the seed held before the edge
    a_r2_load_seed: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cnt_q[g] == $past(seed_q[g]));
    // R5: a disabled core never reaches the output
    a_r5_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      ivl_q[g] == '0 |-> !strobe_o[g]);
  end

  assign strobe_o  = hit & (~hit + 1'b1);
  assign collide_o = (hit & (hit - 1'b1)) != '0;

  a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe_o));
  a_r7_collide_grants: assert property (@(posedge clk) disable iff (!rst_n)
    collide_o |-> $countones(strobe_o) == 1);
  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> strobe_o == '0 && !collide_o);

endmodule

// File: tb/core_interval_arb_tb.sv
module core_interval_arb_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int LIMIT = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0, load = 1'b0;
  logic [3:0] cfg_idx = '0;
  logic [6:0] cfg_data = '0;
  logic [N-1:0] strobe_o;
  logic collide_o;

  core_interval_arb u_dut (.clk, .rst_n, .cfg_we, .cfg_sel, .cfg_idx, .cfg_data,
                           .load, .strobe_o, .collide_o);

  always #(CLK_PERIOD/2) clk = ~clk;

  int m_cnt[N], m_ivl[N], m_seed[N];
  bit m_run;
  int n_cmp = 0, n_bad = 0, cyc = 0;
  string tag = "R1";

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT) begin
      n_bad++;
      $display("FAIL watchdog: act=cycle %0d exp=end before %0d", cyc, LIMIT);
      summary();
    end
  end

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin m_cnt[i] = i; m_ivl[i] = 16; m_seed[i] = i; end
    m_run = 0;
  endtask

  // one cycle: compare at negedge, drive inputs, advance model
  task automatic step(bit rst, bit we, bit sel, int idx, int data, bit ld);
    logic [N-1:0] raw, exp_s;
    bit exp_c;
    @(negedge clk);
    raw = '0;
    for (int i = 0; i < N; i++)
      if (m_run && m_ivl[i] != 0 && m_cnt[i] == m_ivl[i] - 1) raw[i] = 1'b1;
    exp_s = '0;
    for (int i = N - 1; i >= 0; i--) if (raw[i]) exp_s = '0 | (1 << i);
    exp_c = $countones(raw) > 1;
    n_cmp++;
    if (strobe_o !== exp_s) begin
      n_bad++;
      $display("FAIL %s strobe at cycle %0d: act=%h exp=%h", tag, cyc, strobe_o, exp_s);
    end
    n_cmp++;
    if (collide_o !== exp_c) begin
      n_bad++;
      $display("FAIL %s collide at cycle %0d: act=%b exp=%b", tag, cyc, collide_o, exp_c);
    end
    rst_n = !rst; cfg_we = we; cfg_sel = sel; cfg_idx = idx[3:0];
    cfg_data = data[6:0]; load = ld;
    if (rst) model_reset();
    else begin
      for (int i = 0; i < N; i++) begin
        if (ld) m_cnt[i] = m_seed[i];
        else if (m_run) m_cnt[i] = raw[i] ? 0 : (m_cnt[i] + 1) % 128;
      end
      if (ld) m_run = 1;
      if (we) begin
        if (sel) m_seed[idx] = data;
        else     m_ivl[idx]  = data;
      end
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic wr(bit sel, int idx, int data);
    step(0, 1, sel, idx, data, 0);
  endtask

  initial begin
    model_reset();
    tag = "R1";
    for (int k = 0; k < 4; k++) step(1, 0, 0, 0, 0, 0);
    idle(40);                         // R1: idle until first load
    tag = "R4";
    step(0, 0, 0, 0, 0, 1);
    idle(48);                         // R4 round robin 15..0
    tag = "R9";
    for (int i = 0; i < N; i++) wr(0, i, 0);
    tag = "R3";
    wr(0, 3, 8); wr(0, 5, 32); wr(0, 9, 1); wr(0, 12, 127);
    idle(300);                        // R3 mixed rates incl. 1 and 127
    tag = "R7";
    wr(0, 9, 0); wr(0, 12, 0);
    wr(0, 0, 4); wr(0, 1, 4); wr(0, 6, 6);
    wr(1, 0, 2); wr(1, 1, 2); wr(1, 6, 2);
    step(0, 0, 0, 0, 0, 1);           // R7 aligned collisions, R10 reload
    idle(40);
    tag = "R2";
    step(0, 1, 1, 6, 5, 1);           // R2 seed written during load is not used
    idle(30);
    tag = "R5";
    wr(0, 0, 0); wr(0, 1, 0); wr(0, 6, 0); wr(0, 3, 0); wr(0, 5, 0);
    idle(140);                        // R5 all disabled, counters wrap
    tag = "R6";
    wr(1, 2, 100); step(0, 0, 0, 0, 0, 1);
    wr(0, 2, 5);                      // R6 counter above target wraps
    idle(60);
    tag = "R10";
    step(0, 0, 0, 0, 0, 1);           // R10 restart while running
    idle(40);
    summary();
  end
endmodule